// File: doc/BRIEF.md
# Two-Lane Longitudinal Parity Register

This block keeps a running longitudinal parity over the data bytes that move across a 16-bit parallel peripheral bus, in either direction. The parity is stored as two bytes, one for the low data lane and one for the high data lane. Each transfer strobe XORs the bytes it carries into their lanes. A narrow transfer touches only the low lane. A wide transfer updates both lanes in the same cycle.

Software sees one 8-bit read/write register. A view-mode bit decides what a read returns. In folded view the two stored bytes are XORed into a single byte. In lane view one stored byte is returned, picked by a lane-select bit. A write loads the byte that the current view addresses. In folded view a write loads the low lane and zeroes the high lane, so that a folded read returns the value just written. If a sender appends a check byte equal to the XOR of the preceding data, an accumulator that started at zero returns to zero.

Top module: `lpar_reg`

## Requirements
- R1: A narrow transfer (`xfer_vld`=1, `xfer_wide`=0) XORs `xfer_data[7:0]` into the low lane at the clock edge and leaves the high lane unchanged.
- R2: A wide transfer (`xfer_vld`=1, `xfer_wide`=1) XORs `xfer_data[7:0]` into the low lane and `xfer_data[15:8]` into the high lane at the same clock edge.
- R3: Starting from zero, a run of narrow bytes followed by a check byte equal to their XOR leaves the low lane at zero.
- R4: With `view_mode`=0 (folded), `rd_data` equals the low lane XOR the high lane.
- R5: With `view_mode`=1 (lane view), `rd_data` is the low lane when `lane_sel`=0 and the high lane when `lane_sel`=1.
- R6: A write (`wr_en`=1) in folded view loads `wr_data` into the low lane and clears the high lane, so the folded read returns `wr_data`.
- R7: A write in lane view loads `wr_data` into the lane chosen by `lane_sel` and leaves the other lane unchanged.
- R8: When a write and a transfer occur in the same cycle, the write is applied and no lane accumulates the transfer.
- R9: A synchronous active-high `rst` clears both lanes to zero.
- R10: `rd_data` is combinational from the stored lanes, `view_mode` and `lane_sel`. Changing the view bits never changes the stored lanes.
- R11: In a cycle with no write and no transfer, both lanes hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_vld | input | 1 | Data transfer strobe |
| xfer_wide | input | 1 | Transfer uses both lanes |
| xfer_data | input | 16 | Transferred data, low lane in bits 7:0 |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write value |
| view_mode | input | 1 | 0 = folded view, 1 = lane view |
| lane_sel | input | 1 | Lane picked in lane view (1 = high) |
| rd_data | output | 8 | Read view of the parity |

## Verification
A software write and a bus transfer can fall into the same cycle. That collision is the one ordering the design must resolve. The bench provokes it by asserting `wr_en` together with a wide `xfer_vld`, in lane view with the low lane selected. It then reads both lanes through the lane view. The low lane must hold exactly the written value, and the high lane must keep its earlier value with no transfer byte folded into either lane.

// File: rtl/lpar_pkg.sv
package lpar_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 2;

    typedef enum logic {
        VIEW_FOLD = 1'b0,
        VIEW_LANE = 1'b1
    } view_e;

    function automatic logic [BYTE_W-1:0] byte_xor(input logic [BYTE_W-1:0] a,
                                                   input logic [BYTE_W-1:0] b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/lpar_lane.sv
module lpar_lane #(
    parameter int BYTE_W = lpar_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              acc_en,
    input  logic [BYTE_W-1:0] acc_byte,
    output logic [BYTE_W-1:0] q
);
    import lpar_pkg::*;

    logic [BYTE_W-1:0] q_nxt;

    always_comb begin
        q_nxt = q;
        if (load) begin
            q_nxt = load_val;
        end else if (acc_en) begin
            q_nxt = byte_xor(q, acc_byte);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= q_nxt;
        end
    end

    // R9
    lane_reset_chk: assert property (@(posedge clk) rst |=> (q == '0));

    // R6 R7 R8
    lane_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(load_val)));

    // R1 R2
    lane_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !load) |=> (q == ($past(q) ^ $past(acc_byte))));

    // R11
    lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc_en && !load) |=> $stable(q));

endmodule

// File: rtl/lpar_wrsel.sv
module lpar_wrsel #(
    parameter int BYTE_W = lpar_pkg::BYTE_W,
    parameter int LANES  = lpar_pkg::LANES,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                          wr_en,
    input  lpar_pkg::view_e               view,
    input  logic [SEL_W-1:0]              sel,
    input  logic [BYTE_W-1:0]             wr_data,
    output logic [LANES-1:0]              load,
    output logic [LANES-1:0][BYTE_W-1:0]  load_val
);
    import lpar_pkg::*;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            if (view == VIEW_FOLD) begin
                load[i]     = wr_en;
                load_val[i] = (i == 0) ? wr_data : '0;
            end else begin
                load[i]     = wr_en && (sel == SEL_W'(i));
                load_val[i] = wr_data;
            end
        end
    end

endmodule

// File: rtl/lpar_view.sv
module lpar_view #(
    parameter int BYTE_W = lpar_pkg::BYTE_W,
    parameter int LANES  = lpar_pkg::LANES,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0][BYTE_W-1:0] lanes,
    input  lpar_pkg::view_e              view,
    input  logic [SEL_W-1:0]             sel,
    output logic [BYTE_W-1:0]            rd
);
    import lpar_pkg::*;

    logic [BYTE_W-1:0] folded;
    logic [BYTE_W-1:0] picked;

    always_comb begin
        folded = '0;
        picked = '0;
        for (int i = 0; i < LANES; i++) begin
            folded = byte_xor(folded, lanes[i]);
            if (sel == SEL_W'(i)) begin
                picked = lanes[i];
            end
        end
        rd = (view == VIEW_FOLD) ? folded : picked;
    end

endmodule

// File: rtl/lpar_reg.sv
module lpar_reg #(
    parameter int BYTE_W = lpar_pkg::BYTE_W,
    parameter int LANES  = lpar_pkg::LANES,
    localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int DATA_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_vld,
    input  logic              xfer_wide,
    input  logic [DATA_W-1:0] xfer_data,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              view_mode,
    input  logic [SEL_W-1:0]  lane_sel,
    output logic [BYTE_W-1:0] rd_data
);
    import lpar_pkg::*;

    view_e                         view;
    logic [LANES-1:0]              load;
    logic [LANES-1:0][BYTE_W-1:0]  load_val;
    logic [LANES-1:0][BYTE_W-1:0]  lanes;
    logic [LANES-1:0]              acc_en;

    assign view = view_e'(view_mode);

    lpar_wrsel #(.BYTE_W(BYTE_W), .LANES(LANES)) u_wrsel (
        .wr_en    (wr_en),
        .view     (view),
        .sel      (lane_sel),
        .wr_data  (wr_data),
        .load     (load),
        .load_val (load_val)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == 0) begin : g_low
            assign acc_en[i] = xfer_vld && !wr_en;
        end else begin : g_up
            assign acc_en[i] = xfer_vld && xfer_wide && !wr_en;
        end

        lpar_lane #(.BYTE_W(BYTE_W)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .load     (load[i]),
            .load_val (load_val[i]),
            .acc_en   (acc_en[i]),
            .acc_byte (xfer_data[i*BYTE_W +: BYTE_W]),
            .q        (lanes[i])
        );
    end

    lpar_view #(.BYTE_W(BYTE_W), .LANES(LANES)) u_view (
        .lanes (lanes),
        .view  (view),
        .sel   (lane_sel),
        .rd    (rd_data)
    );

    // R8
    wr_blocks_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && xfer_vld && view_mode && (lane_sel == '0)) |=> $stable(lanes[LANES-1]));

    // R10
    view_keeps_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !xfer_vld) |=> $stable(lanes));

endmodule

// File: tb/lpar_reg_tb.sv
module lpar_reg_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    typedef struct packed {
        logic        vld;
        logic        wide;
        logic [15:0] data;
        logic        wr;
        logic [7:0]  wdata;
        logic        mode;
        logic        sel;
        logic [7:0]  exp;
        logic [7:0]  req;
    } vec_t;

    // Walk from reset; each entry is one clock, rd sampled after the edge.
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 16'h003C, 1'b0, 8'h00, 1'b0, 1'b0, 8'h3C, 8'd1},  // R1 fold
        '{1'b1, 1'b0, 16'h00A5, 1'b0, 8'h00, 1'b1, 1'b0, 8'h99, 8'd1},  // R1
        '{1'b0, 1'b0, 16'h0000, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 8'd1},  // R1 high untouched
        '{1'b1, 1'b1, 16'h1234, 1'b0, 8'h00, 1'b1, 1'b1, 8'h12, 8'd2},  // R2 high
        '{1'b0, 1'b0, 16'h0000, 1'b0, 8'h00, 1'b1, 1'b0, 8'hAD, 8'd5},  // R5 low
        '{1'b0, 1'b0, 16'h0000, 1'b0, 8'h00, 1'b0, 1'b0, 8'hBF, 8'd4},  // R4 R10
        '{1'b0, 1'b0, 16'h0000, 1'b1, 8'h5A, 1'b0, 1'b0, 8'h5A, 8'd6},  // R6
        '{1'b0, 1'b0, 16'h0000, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 8'd6},  // R6 high cleared
        '{1'b0, 1'b0, 16'h0000, 1'b1, 8'h77, 1'b1, 1'b1, 8'h77, 8'd7},  // R7
        '{1'b0, 1'b0, 16'h0000, 1'b0, 8'h00, 1'b1, 1'b0, 8'h5A, 8'd7},  // R7 low kept
        '{1'b1, 1'b1, 16'hFFFF, 1'b1, 8'h0F, 1'b1, 1'b0, 8'h0F, 8'd8},  // R8 collision
        '{1'b0, 1'b0, 16'h0000, 1'b0, 8'h00, 1'b1, 1'b1, 8'h77, 8'd8},  // R8 high kept
        '{1'b0, 1'b0, 16'h0000, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 8'd6},  // R6 zero
        '{1'b1, 1'b0, 16'h005A, 1'b0, 8'h00, 1'b1, 1'b0, 8'h5A, 8'd3},  // R3
        '{1'b1, 1'b0, 16'h00C3, 1'b0, 8'h00, 1'b1, 1'b0, 8'h99, 8'd3},  // R3
        '{1'b1, 1'b0, 16'h000F, 1'b0, 8'h00, 1'b1, 1'b0, 8'h96, 8'd3},  // R3
        '{1'b1, 1'b0, 16'h0096, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 8'd3},  // R3 check byte
        '{1'b1, 1'b1, 16'hABCD, 1'b0, 8'h00, 1'b0, 1'b0, 8'h66, 8'd2}   // R2 R4
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        xfer_vld, xfer_wide, wr_en, view_mode, lane_sel;
    logic [15:0] xfer_data;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpar_reg u_dut (
        .clk       (clk),
        .rst       (rst),
        .xfer_vld  (xfer_vld),
        .xfer_wide (xfer_wide),
        .xfer_data (xfer_data),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .view_mode (view_mode),
        .lane_sel  (lane_sel),
        .rd_data   (rd_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle();
        xfer_vld = 1'b0; xfer_wide = 1'b0; xfer_data = '0;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; idle(); view_mode = 1'b0; lane_sel = 1'b0;
        @(negedge clk); step();
        rst = 1'b0;
        // R9 reset state in each view
        check("R9 fold", rd_data, 8'h00);
        view_mode = 1'b1; lane_sel = 1'b1; #1;
        check("R9 high", rd_data, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            xfer_vld  = VECS[i].vld;
            xfer_wide = VECS[i].wide;
            xfer_data = VECS[i].data;
            wr_en     = VECS[i].wr;
            wr_data   = VECS[i].wdata;
            view_mode = VECS[i].mode;
            lane_sel  = VECS[i].sel;
            step();
            check($sformatf("R%0d vec%0d", VECS[i].req, i), rd_data, VECS[i].exp);
        end

        // R10 view toggles without a clock edge leave lanes intact (lo=CD, hi=AB)
        idle();
        view_mode = 1'b1; lane_sel = 1'b0; #1;
        check("R10 low", rd_data, 8'hCD);
        lane_sel = 1'b1; #1;
        check("R10 high", rd_data, 8'hAB);
        // R11 idle cycles hold
        step(); step();
        check("R11 hold high", rd_data, 8'hAB);
        view_mode = 1'b0; #1;
        check("R11 hold fold", rd_data, 8'h66);

        // R9 reset from a non-zero state, with a transfer pending
        rst = 1'b1; xfer_vld = 1'b1; xfer_wide = 1'b1; xfer_data = 16'h5555;
        step();
        rst = 1'b0; idle();
        check("R9 fold after rst", rd_data, 8'h00);
        view_mode = 1'b1; lane_sel = 1'b0; #1;
        check("R9 low after rst", rd_data, 8'h00);
        lane_sel = 1'b1; #1;
        check("R9 high after rst", rd_data, 8'h00);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: done=0 expected=1");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule